// File: doc/BRIEF.md
# Phased-Access Cache Way Selector

This block steers the way enables of a second-level cache whose tag and data arrays are read in two consecutive phases. A request arrives with a status bit that says whether it came from a first-level write hit, plus a one-hot way-enable taken from a buffer of remembered way tags. In the first phase the block decides which tag-array ways to power. In the second phase it decides which data-array way to power.

A write hit already knows its destination way. For such a request the block leaves every tag-array way off and drives the data way straight from the buffered decoder value. Any other request (a write miss or a read miss) powers all tag ways. The per-way compare results that come back then pick the data way. When no way matches, the block raises a miss flag instead of a data enable. When several ways match, it picks the lowest-numbered one and raises an error flag. Every request takes the same two-cycle slot, so way tagging adds no latency to the plain phased scheme.

Top module: `waysel_top`

## Requirements
- R1: After synchronous reset the block is idle: all tag enables, data enables, done, miss and error outputs are 0, and ready is 1.
- R2: A request (req_valid=1 while ready=1) is captured at a clock edge. Tag enables are then valid for one cycle (phase one), and data enables, done, miss and error are valid for the next cycle (phase two). The block then returns to idle with ready=1.
- R3: For a write-hit request (req_wr_hit=1), every tag-enable bit stays 0 during phase one.
- R4: For a write-hit request, the data enable in phase two equals the req_way value captured with the request. Tag compare results are ignored, and miss and error stay 0.
- R5: For any other request (req_wr_hit=0), all tag-enable bits are 1 during phase one.
- R6: For a non-write-hit request with exactly one compare bit set during phase one, the data enable in phase two is that single bit. Miss and error are 0.
- R7: For a non-write-hit request with no compare bit set, the data enable is all 0 and miss is 1 in phase two.
- R8: For a non-write-hit request with two or more compare bits set, the data enable is the lowest-numbered matching way and error is 1 in phase two.
- R9: done is a single-cycle pulse in phase two of every request. ready is 0 from the capture edge until done. A req_valid seen while ready is 0 is not captured.
- R10: Data enables are nonzero only in phase two and carry at most one set bit. Tag enables are nonzero only in phase one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when ready is 1 |
| req_wr_hit | input | 1 | Buffered status: request is a first-level write hit |
| req_way | input | WAYS | One-hot way enable from the way-tag decoder |
| tag_match | input | WAYS | Per-way tag compare results, sampled in phase one |
| ready | output | 1 | Block idle and able to take a request |
| tag_en | output | WAYS | Per-way tag-array enables (phase one) |
| data_en | output | WAYS | Per-way data-array enables (phase two) |
| done | output | 1 | One-cycle pulse at the end of phase two |
| miss | output | 1 | No way matched on a looked-up request |
| multi_err | output | 1 | More than one way matched on a looked-up request |

## Verification
The assertions assume that req_way is one-hot, or zero, whenever a write-hit request is taken. They assume that tag_match is only meaningful during the phase-one cycle. Each stimulus request therefore drives a one-hot req_way, or one of the few zero-or-one-hot patterns the sweep picks. The compare vector is applied only while the tag enables are up and is forced to zero at all other times. With four ways, the bench sweeps every compare pattern for looked-up requests and every way for write hits. It also checks that a request presented while busy is dropped and that compare values on write hits change nothing.

// File: rtl/waysel_pkg.sv
package waysel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAG  = 2'd1,
    ST_DATA = 2'd2
  } waysel_state_t;
endpackage

// File: rtl/waysel_prio.sv
module waysel_prio #(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0] vec,
  output logic [WAYS-1:0] first,
  output logic            none,
  output logic            many
);
  logic [WAYS:0] seen;
  assign seen[0] = 1'b0;
  generate
    for (genvar i = 0; i < WAYS; i++) begin : g_scan
      assign first[i]  = vec[i] & ~seen[i];
      assign seen[i+1] = seen[i] | vec[i];
    end
  endgenerate
  assign none = ~seen[WAYS];
  assign many = (vec & ~first) != '0;
endmodule

// File: rtl/waysel_ctrl.sv
module waysel_ctrl
  import waysel_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output waysel_state_t state,
  output logic          capture
);
  waysel_state_t nxt;
  assign capture = (state == ST_IDLE) && req_valid;
  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (req_valid) nxt = ST_TAG;
      ST_TAG:  nxt = ST_DATA;
      ST_DATA: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end
  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAG) |=> (state == ST_DATA));
  // R2
  back_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |=> (state == ST_IDLE));
endmodule

// File: rtl/waysel_top.sv
module waysel_top
  import waysel_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_wr_hit,
  input  logic [WAYS-1:0] req_way,
  input  logic [WAYS-1:0] tag_match,
  output logic            ready,
  output logic [WAYS-1:0] tag_en,
  output logic [WAYS-1:0] data_en,
  output logic            done,
  output logic            miss,
  output logic            multi_err
);
  localparam logic [WAYS-1:0] ALL_WAYS = '1;

  waysel_state_t state;
  logic          capture;
  logic          hit_q;
  logic [WAYS-1:0] way_q;
  logic [WAYS-1:0] first;
  logic          none, many;

  waysel_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .state(state), .capture(capture)
  );

  waysel_prio #(.WAYS(WAYS)) u_prio (
    .vec(tag_match), .first(first), .none(none), .many(many)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q     <= 1'b0;
      way_q     <= '0;
      ready     <= 1'b1;
      tag_en    <= '0;
      data_en   <= '0;
      done      <= 1'b0;
      miss      <= 1'b0;
      multi_err <= 1'b0;
    end else begin
      data_en   <= '0;
      done      <= 1'b0;
      miss      <= 1'b0;
      multi_err <= 1'b0;
      tag_en    <= '0;
      if (capture) begin
        hit_q  <= req_wr_hit;
        way_q  <= req_way;
        ready  <= 1'b0;
        tag_en <= req_wr_hit ? '0 : ALL_WAYS;
      end
      if (state == ST_TAG) begin
        done <= 1'b1;
        if (hit_q) begin
          data_en <= way_q;
        end else begin
          data_en   <= first;
          miss      <= none;
          multi_err <= many;
        end
      end
      if (state == ST_DATA) ready <= 1'b1;
    end
  end

  // R10
  data_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(data_en));
  // R10
  data_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (data_en != '0) |-> done);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  ready_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid) |=> !ready);
  // R3
  skip_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && req_wr_hit) |=> (tag_en == '0));
  // R5
  full_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && !req_wr_hit) |=> (tag_en == ALL_WAYS));
  // R7
  miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    miss |-> (data_en == '0) && done);
  // R8
  err_has_way_chk: assert property (@(posedge clk) disable iff (rst)
    multi_err |-> (data_en != '0) && !miss);
endmodule

// File: tb/sim_waysel_top.sv
module sim_waysel_top;
  localparam int WAYS = 4;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_wr_hit = 0;
  logic [WAYS-1:0] req_way = '0, tag_match = '0;
  logic ready, done, miss, multi_err;
  logic [WAYS-1:0] tag_en, data_en;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  waysel_top #(.WAYS(WAYS)) u0 (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [WAYS-1:0] low_bit(input logic [WAYS-1:0] v);
    for (int i = 0; i < WAYS; i++) if (v[i]) return WAYS'(1) << i;
    return '0;
  endfunction

  // one full access; inputs changed at negedge, outputs sampled at negedge
  task automatic access(input bit wh, input logic [WAYS-1:0] way, input logic [WAYS-1:0] mt);
    logic [WAYS-1:0] expd;
    int n;
    @(negedge clk);
    req_valid = 1; req_wr_hit = wh; req_way = way;
    @(negedge clk);
    req_valid = 1; req_wr_hit = ~wh; req_way = ~way; // busy: must be ignored (R9)
    chk(ready == 0, "R9 ready low", ready, 0);
    if (wh) chk(tag_en == '0, "R3 tag off", tag_en, 0);
    else    chk(tag_en == '1, "R5 tag all", tag_en, 4'hf);
    chk(data_en == '0 && !done, "R10 no data in phase1", data_en, 0);
    tag_match = mt;
    @(negedge clk);
    req_valid = 0; tag_match = '0;
    n = $countones(mt);
    chk(done == 1, "R2 done", done, 1);
    if (wh) begin
      chk(data_en == way && !miss && !multi_err, "R4 direct way", {miss, multi_err, data_en}, way);
    end else begin
      expd = low_bit(mt);
      if (n == 1) chk(data_en == expd && !miss && !multi_err, "R6 single match", {miss, multi_err, data_en}, expd);
      else if (n == 0) chk(data_en == '0 && miss && !multi_err, "R7 miss", {miss, multi_err, data_en}, 16'h20);
      else chk(data_en == expd && !miss && multi_err, "R8 multi", {miss, multi_err, data_en}, {2'b01, expd});
    end
    chk(tag_en == '0, "R10 tag off in phase2", tag_en, 0);
    @(negedge clk);
    chk(ready == 1 && !done && data_en == '0, "R2 back idle", {ready, done, data_en}, 16'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready && tag_en == '0 && data_en == '0 && !done && !miss && !multi_err,
        "R1 reset", {ready, done, miss, multi_err, tag_en, data_en}, 16'h800);
    rst = 0;
    for (int w = 0; w < WAYS; w++)
      for (int m = 0; m < (1 << WAYS); m++)
        access(1'b1, WAYS'(1) << w, WAYS'(m));
    for (int m = 0; m < (1 << WAYS); m++)
      access(1'b0, WAYS'(1) << (m % WAYS), WAYS'(m));
    // idle with no request: nothing moves
    @(negedge clk);
    chk(ready && !done && tag_en == '0, "R2 idle stays", {ready, done, tag_en}, 16'h20);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin repeat (20000) @(posedge clk); errors++; checks++; $display("FAIL watchdog expired"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule